// File: doc/BRIEF.md
# Nibble-Loaded ROM Table-Read Pointer

This block lets a 4-bit datapath read constant tables held in an 8-bit-wide program ROM. A 12-bit pointer is built up from three separate 4-bit writes taken from the accumulator, one each for the low, middle and high nibble. Each byte of the table is then fetched as two nibbles. The low-nibble read leaves the pointer where it is. The high-nibble read advances the pointer by one, so a loop of low read followed by high read streams through consecutive bytes.

The ROM is modelled as a synchronous array inside the block. The environment fills it through a byte-wide initialisation port before use. Only the low index bits of the pointer select a ROM entry, so a depth smaller than 4096 wraps the pointer onto the array. A read result appears one clock after its strobe. A pointer increment takes effect on that same edge.

Top module: `nibble_table_ptr`

## Requirements
- R1: While reset is active and in the first cycle after it, `rom_addr` is 000h and `rd_valid` is 0.
- R2: `ld_lo`, `ld_mid` and `ld_hi` copy `acc_in` into pointer bits [3:0], [7:4] and [11:8] respectively on the next edge. Bits whose strobe is low keep their value. Several load strobes in one cycle all take effect.
- R3: `rd_lo` alone, with no load strobe, gives `rd_data` = bits [3:0] of the ROM byte at the pointer one cycle later and leaves the pointer unchanged.
- R4: `rd_hi`, with no load strobe, gives `rd_data` = bits [7:4] of the ROM byte at the pointer one cycle later. The pointer is incremented by one on that same edge.
- R5: A high-nibble read with the pointer at FFFh leaves the pointer at 000h.
- R6: When any load strobe is high, a read strobe in the same cycle is ignored: no `rd_valid`, no increment, and the loads apply as in R2.
- R7: When `rd_lo` and `rd_hi` are high together without a load, the high-nibble read of R4 is performed.
- R8: `rd_valid` is high exactly in the cycle after an accepted read. `rd_data` keeps its last value while no read is accepted. With no strobes the pointer holds.
- R9: The ROM entry read is the one at index `rom_addr` modulo ROM_DEPTH. It holds the byte last written to that index through `init_we`/`init_addr`/`init_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 4 | Accumulator nibble for pointer loads |
| ld_lo | input | 1 | Load pointer bits [3:0] |
| ld_mid | input | 1 | Load pointer bits [7:4] |
| ld_hi | input | 1 | Load pointer bits [11:8] |
| rd_lo | input | 1 | Read low nibble of ROM byte at pointer |
| rd_hi | input | 1 | Read high nibble and post-increment pointer |
| init_we | input | 1 | ROM initialisation write enable |
| init_addr | input | 11 | ROM initialisation index |
| init_data | input | 8 | ROM initialisation byte |
| rom_addr | output | 12 | Current pointer, the ROM address |
| rd_data | output | 4 | Nibble returned to the accumulator |
| rd_valid | output | 1 | `rd_data` updated by a read this cycle |

## Verification
The assertions assume that the strobes are clean synchronous levels that are never unknown once reset is released. They also assume that the ROM is not rewritten through the initialisation port while table reads are in flight. The stimulus keeps to this in two ways. It fills the whole ROM during reset, before any strobe is raised. It then drives every strobe at the falling edge, one operation per cycle. These operations include the deliberate load-and-read and dual-read collisions.

// File: rtl/nibble_table_ptr.sv
module nibble_table_ptr #(
  parameter int NIB_W     = 4,
  parameter int ROM_DEPTH = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NIB_W-1:0]             acc_in,
  input  logic                         ld_lo,
  input  logic                         ld_mid,
  input  logic                         ld_hi,
  input  logic                         rd_lo,
  input  logic                         rd_hi,
  input  logic                         init_we,
  input  logic [$clog2(ROM_DEPTH)-1:0] init_addr,
  input  logic [2*NIB_W-1:0]           init_data,
  output logic [3*NIB_W-1:0]           rom_addr,
  output logic [NIB_W-1:0]             rd_data,
  output logic                         rd_valid
);
  localparam int PTR_W  = 3 * NIB_W;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int IDX_W  = $clog2(ROM_DEPTH);

  logic [BYTE_W-1:0] rom_mem [ROM_DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] byte_q;
  logic              hi_sel_q;
  logic              valid_q;

  wire load_any = ld_lo | ld_mid | ld_hi;
  wire rd_go    = (rd_lo | rd_hi) & ~load_any;
  wire rd_up    = rd_hi & ~load_any;

  always_ff @(posedge clk)
    if (init_we) rom_mem[init_addr] <= init_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_any) begin
      if (ld_lo)  ptr_q[NIB_W-1:0]         <= acc_in;
      if (ld_mid) ptr_q[2*NIB_W-1:NIB_W]   <= acc_in;
      if (ld_hi)  ptr_q[PTR_W-1:2*NIB_W]   <= acc_in;
    end else if (rd_up) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q   <= '0;
      hi_sel_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= rd_go;
      if (rd_go) begin
        byte_q   <= rom_mem[ptr_q[IDX_W-1:0]];
        hi_sel_q <= rd_hi;
      end
    end
  end

  assign rom_addr = ptr_q;
  assign rd_valid = valid_q;
  assign rd_data  = hi_sel_q ? byte_q[BYTE_W-1:NIB_W] : byte_q[NIB_W-1:0];
endmodule

// File: rtl/nibble_table_ptr_chk.sv
module nibble_table_ptr_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NIB_W-1:0]   acc_in,
  input logic               ld_lo,
  input logic               ld_mid,
  input logic               ld_hi,
  input logic               rd_lo,
  input logic               rd_hi,
  input logic [3*NIB_W-1:0] rom_addr,
  input logic               rd_valid
);
  localparam int PW = 3 * NIB_W;
  wire any_ld = ld_lo | ld_mid | ld_hi;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (rom_addr == '0 && !rd_valid));

  p_load_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> rom_addr[NIB_W-1:0] == $past(acc_in));

  p_load_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> rom_addr[PW-1:2*NIB_W] == $past(acc_in));

  p_lo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && !any_ld) |=> $stable(rom_addr));

  p_hi_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !any_ld) |=> rom_addr == PW'($past(rom_addr) + 1'b1));

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_ld |=> !rd_valid);

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo || rd_hi) && !any_ld |=> rd_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_ld || rd_lo || rd_hi) |=> ($stable(rom_addr) && !rd_valid));
endmodule

bind nibble_table_ptr nibble_table_ptr_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ld_lo(ld_lo), .ld_mid(ld_mid),
  .ld_hi(ld_hi), .rd_lo(rd_lo), .rd_hi(rd_hi), .rom_addr(rom_addr), .rd_valid(rd_valid)
);

// File: tb/nibble_table_ptr_bench.sv
module nibble_table_ptr_bench;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  acc_in = '0;
  logic        ld_lo = 0, ld_mid = 0, ld_hi = 0, rd_lo = 0, rd_hi = 0;
  logic        init_we = 0;
  logic [10:0] init_addr = '0;
  logic [7:0]  init_data = '0;
  logic [11:0] rom_addr;
  logic [3:0]  rd_data;
  logic        rd_valid;

  nibble_table_ptr u_nibble_table_ptr (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .ld_lo(ld_lo), .ld_mid(ld_mid),
    .ld_hi(ld_hi), .rd_lo(rd_lo), .rd_hi(rd_hi), .init_we(init_we),
    .init_addr(init_addr), .init_data(init_data), .rom_addr(rom_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0]  rom_m [DEPTH];
  logic [11:0] dp_m = '0;
  logic [3:0]  exp_q [$];
  string       tag_q [$];
  bit          mon_on = 0;
  bit          done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(0, "R8 spurious rd_valid", 1, 0);
      else begin
        automatic logic [3:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic step(bit l0, bit l1, bit l2, bit r0, bit r1, logic [3:0] a, string tag);
    ld_lo = l0; ld_mid = l1; ld_hi = l2; rd_lo = r0; rd_hi = r1; acc_in = a;
    if (l0 | l1 | l2) begin
      if (l0) dp_m[3:0]  = a;
      if (l1) dp_m[7:4]  = a;
      if (l2) dp_m[11:8] = a;
    end else if (r1) begin
      exp_q.push_back(rom_m[dp_m[10:0]][7:4]); tag_q.push_back(tag);
      dp_m = dp_m + 1'b1;
    end else if (r0) begin
      exp_q.push_back(rom_m[dp_m[10:0]][3:0]); tag_q.push_back(tag);
    end
    @(negedge clk);
    ld_lo = 0; ld_mid = 0; ld_hi = 0; rd_lo = 0; rd_hi = 0;
    check(rom_addr == dp_m, {tag, " pointer"}, rom_addr, dp_m);
  endtask

  task automatic load_ptr(logic [11:0] v);
    step(0, 0, 1, 0, 0, v[11:8], "R2");
    step(0, 1, 0, 0, 0, v[7:4], "R2");
    step(1, 0, 0, 0, 0, v[3:0], "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) rom_m[i] = 8'((i * 37 + 5) ^ (i >> 3));
    rom_m[11'h777] = 8'h56;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      init_we = 1; init_addr = 11'(i); init_data = rom_m[i];
      @(negedge clk);
    end
    init_we = 0;
    check(rom_addr == 12'h000 && !rd_valid, "R1 reset", rom_addr, 0);
    rst_n = 1;
    @(negedge clk);
    check(rom_addr == 12'h000 && !rd_valid, "R1 after reset", rom_addr, 0);
    mon_on = 1;

    load_ptr(12'h777);
    step(0, 0, 0, 1, 0, 0, "R3 low read 777h");
    step(0, 0, 0, 0, 1, 0, "R4 high read 777h");
    step(0, 0, 0, 0, 0, 0, "R8 idle");
    check(rd_data == 4'h5, "R8 rd_data hold", rd_data, 5);

    step(1, 1, 1, 0, 0, 4'hA, "R2 triple load");
    step(0, 1, 0, 0, 0, 4'h3, "R2 mid only");
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 1, 0, 0, "R3 stream low");
      step(0, 0, 0, 0, 1, 0, "R4 stream high");
    end

    load_ptr(12'hFFE);
    step(0, 0, 0, 0, 1, 0, "R4 high FFEh");
    step(0, 0, 0, 0, 1, 0, "R5 wrap FFFh");
    check(rom_addr == 12'h000, "R5 wrapped", rom_addr, 0);

    load_ptr(12'h123);
    step(1, 0, 0, 0, 1, 4'h9, "R6 load vs high read");
    step(0, 0, 0, 0, 0, 0, "R6 idle");
    step(0, 1, 0, 1, 0, 4'h4, "R6 load vs low read");
    step(0, 0, 0, 0, 0, 0, "R6 idle");

    step(0, 0, 0, 1, 1, 0, "R7 dual read");
    step(0, 0, 0, 1, 1, 0, "R7 dual read 2");

    load_ptr(12'hF42);
    step(0, 0, 0, 1, 0, 0, "R9 alias low");
    step(0, 0, 0, 0, 1, 0, "R9 alias high");
    step(0, 0, 0, 0, 0, 0, "R8 idle");
    step(0, 0, 0, 0, 0, 0, "R8 idle");
    check(exp_q.size() == 0, "R8 missing rd_valid", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule